// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two direction predictors side by side and lets a trained selector choose between them for each branch. The first, the path predictor, keeps a shift register of the outcomes of the most recent branches. That register indexes a table of 2-bit saturating counters. The second, the per-branch predictor, uses fetch-address bits to pick a history register from a table of per-branch outcome histories. The history it picks then indexes a table of 3-bit saturating counters. The selector is a third table of 2-bit counters, indexed by the same path history. It learns which of the two predictors to trust.

A lookup is combinational. Present a fetch address, and in the same cycle the block returns the final direction and both component directions. When the branch resolves, the pipeline returns the branch address, the real outcome and the two component directions that the lookup gave. On that clock edge the block trains all three tables and shifts the outcome into both histories. Histories move only on resolution, so the block expects branches to resolve in program order. There is no speculative history and no target prediction.

Top module: `tournament_predictor`

## Requirements
- R1: After synchronous reset, every counter of both component tables reads weakly not-taken and every history is zero. The final, path and per-branch predictions are therefore all 0 (not taken) for any address. The selector entries reset to weakly favouring the per-branch predictor (value 1).
- R2: The path history is 12 bits. On each resolution it shifts left by one and the outcome enters bit 0, so bit i holds the outcome of the i-th most recent resolved branch (1 = taken).
- R3: The path prediction is the upper bit of the 2-bit counter indexed by the current path history. On resolution, that counter steps toward the outcome and saturates at 0 and 3.
- R4: The per-branch history table has 1024 entries of 10 bits, indexed by address bits [11:2]. On resolution, the entry selected by the resolved address shifts left and takes the outcome in bit 0.
- R5: The per-branch prediction is taken when the 3-bit counter indexed by the selected 10-bit history is 4 or more. On resolution, the counter indexed by the resolved entry's pre-shift history steps toward the outcome and saturates at 0 and 7.
- R6: The selector counter indexed by the current path history picks the source: values 2 and 3 choose the path prediction, values 0 and 1 choose the per-branch prediction. The final prediction equals the chosen one.
- R7: On resolution, the selector counter changes only when the two returned component directions differ. It steps up when the path direction matched the outcome and down otherwise, saturating at 0 and 3.
- R8: Whenever the two component predictions agree, the final prediction equals them.
- R9: While no resolution is presented, no table or history changes, and the outputs for a given address stay the same.
- R10: A lookup in the same cycle as a resolution reflects the state before that resolution. The update is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_pc | input | 32 | Fetch address to predict |
| pred_taken | output | 1 | Final direction (1 = taken) |
| pred_global | output | 1 | Path-history predictor direction |
| pred_local | output | 1 | Per-branch predictor direction |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Real outcome of the resolving branch |
| res_pred_global | input | 1 | Path direction given at lookup of that branch |
| res_pred_local | input | 1 | Per-branch direction given at lookup of that branch |

## Verification
A wrong path history shows up at the next lookup as a path prediction or final choice taken from the wrong entry. A counter that steps or saturates wrongly is seen only when its entry is looked up again, and that can be several resolutions later. A corrupted per-branch history shows first on the address that maps to it, and it can also show on an aliasing address that shares bits [11:2]. A selector that trains on agreement, or in the wrong direction, flips the final prediction away from the component that has been right. A bench model of all three tables, advanced on every resolution, exposes each of these at the first lookup that touches the damaged entry.

// File: rtl/tp_pkg.sv
package tp_pkg;

    localparam int TP_PC_W      = 32;
    localparam int TP_PATH_W    = 12;
    localparam int TP_BIDX_W    = 10;
    localparam int TP_BHIST_W   = 10;
    localparam int TP_PCTR_W    = 2;
    localparam int TP_BCTR_W    = 3;
    localparam int TP_SEL_W     = 2;

    typedef enum logic [1:0] {
        SEL_BRANCH_STRONG = 2'd0,
        SEL_BRANCH_WEAK   = 2'd1,
        SEL_PATH_WEAK     = 2'd2,
        SEL_PATH_STRONG   = 2'd3
    } sel_state_e;

    typedef struct packed {
        logic valid;
        logic taken;
        logic path_dir;
        logic branch_dir;
    } resolve_t;

    typedef struct packed {
        logic final_dir;
        logic path_dir;
        logic branch_dir;
    } verdict_t;

    function automatic sel_state_e sel_train(sel_state_e cur, logic toward_path);
        sel_state_e nxt;
        nxt = cur;
        if (toward_path) begin
            if (cur != SEL_PATH_STRONG) nxt = sel_state_e'(cur + 2'd1);
        end else begin
            if (cur != SEL_BRANCH_STRONG) nxt = sel_state_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/tp_path_pred.sv
module tp_path_pred #(
    parameter int HIST_W = tp_pkg::TP_PATH_W,
    parameter int CTR_W  = tp_pkg::TP_PCTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic              upd_taken,
    output logic [HIST_W-1:0] path_hist,
    output logic              dir
);
    localparam int DEPTH = 1 << HIST_W;
    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_INIT = {1'b0, {(CTR_W-1){1'b1}}};

    logic [CTR_W-1:0]  ctr_tbl [DEPTH];
    logic [HIST_W-1:0] hist_q;
    logic [CTR_W-1:0]  cur_ctr;

    assign path_hist = hist_q;
    assign cur_ctr   = ctr_tbl[hist_q];
    assign dir       = cur_ctr[CTR_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            for (int i = 0; i < DEPTH; i++) ctr_tbl[i] <= CTR_INIT;
        end else if (upd_valid) begin
            hist_q <= {hist_q[HIST_W-2:0], upd_taken};
            if (upd_taken && cur_ctr != CTR_MAX)
                ctr_tbl[hist_q] <= cur_ctr + 1'b1;
            else if (!upd_taken && cur_ctr != '0)
                ctr_tbl[hist_q] <= cur_ctr - 1'b1;
        end
    end
endmodule

// File: rtl/tp_branch_pred.sv
module tp_branch_pred #(
    parameter int PC_W   = tp_pkg::TP_PC_W,
    parameter int IDX_W  = tp_pkg::TP_BIDX_W,
    parameter int HIST_W = tp_pkg::TP_BHIST_W,
    parameter int CTR_W  = tp_pkg::TP_BCTR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lookup_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    output logic            dir
);
    localparam int HT_DEPTH  = 1 << IDX_W;
    localparam int CT_DEPTH  = 1 << HIST_W;
    localparam int IDX_LO    = 2;
    localparam int IDX_HI    = IDX_LO + IDX_W - 1;
    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_INIT = {1'b0, {(CTR_W-1){1'b1}}};

    logic [HIST_W-1:0] hist_tbl [HT_DEPTH];
    logic [CTR_W-1:0]  ctr_tbl  [CT_DEPTH];

    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [HIST_W-1:0] rd_hist, wr_hist;
    logic [CTR_W-1:0]  rd_ctr, wr_ctr;
    logic              unused_pc_bits;

    assign rd_idx  = lookup_pc[IDX_HI:IDX_LO];
    assign wr_idx  = upd_pc[IDX_HI:IDX_LO];
    assign rd_hist = hist_tbl[rd_idx];
    assign wr_hist = hist_tbl[wr_idx];
    assign rd_ctr  = ctr_tbl[rd_hist];
    assign wr_ctr  = ctr_tbl[wr_hist];
    assign dir     = rd_ctr[CTR_W-1];

    assign unused_pc_bits = ^{lookup_pc[PC_W-1:IDX_HI+1], lookup_pc[IDX_LO-1:0],
                              upd_pc[PC_W-1:IDX_HI+1], upd_pc[IDX_LO-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HT_DEPTH; i++) hist_tbl[i] <= '0;
            for (int j = 0; j < CT_DEPTH; j++) ctr_tbl[j] <= CTR_INIT;
        end else if (upd_valid) begin
            hist_tbl[wr_idx] <= {wr_hist[HIST_W-2:0], upd_taken};
            if (upd_taken && wr_ctr != CTR_MAX)
                ctr_tbl[wr_hist] <= wr_ctr + 1'b1;
            else if (!upd_taken && wr_ctr != '0)
                ctr_tbl[wr_hist] <= wr_ctr - 1'b1;
        end
    end
endmodule

// File: rtl/tp_selector.sv
module tp_selector #(
    parameter int IDX_W = tp_pkg::TP_PATH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             upd_valid,
    input  logic             upd_taken,
    input  logic             upd_path_dir,
    input  logic             upd_branch_dir,
    output logic             use_path
);
    import tp_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    sel_state_e sel_tbl [DEPTH];
    sel_state_e cur;

    assign cur      = sel_tbl[idx];
    assign use_path = (cur == SEL_PATH_WEAK) || (cur == SEL_PATH_STRONG);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) sel_tbl[i] <= SEL_BRANCH_WEAK;
        end else if (upd_valid && (upd_path_dir != upd_branch_dir)) begin
            sel_tbl[idx] <= sel_train(cur, upd_path_dir == upd_taken);
        end
    end
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
    parameter int PC_W     = tp_pkg::TP_PC_W,
    parameter int PATH_W   = tp_pkg::TP_PATH_W,
    parameter int BIDX_W   = tp_pkg::TP_BIDX_W,
    parameter int BHIST_W  = tp_pkg::TP_BHIST_W,
    parameter int PCTR_W   = tp_pkg::TP_PCTR_W,
    parameter int BCTR_W   = tp_pkg::TP_BCTR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lookup_pc,
    output logic            pred_taken,
    output logic            pred_global,
    output logic            pred_local,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic            res_pred_global,
    input  logic            res_pred_local
);
    import tp_pkg::*;

    resolve_t          rsv;
    verdict_t          vd;
    logic [PATH_W-1:0] ghist;
    logic              use_path;

    assign rsv = '{valid: res_valid, taken: res_taken,
                   path_dir: res_pred_global, branch_dir: res_pred_local};

    tp_path_pred #(.HIST_W(PATH_W), .CTR_W(PCTR_W)) u_path (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (rsv.valid),
        .upd_taken (rsv.taken),
        .path_hist (ghist),
        .dir       (vd.path_dir)
    );

    tp_branch_pred #(.PC_W(PC_W), .IDX_W(BIDX_W), .HIST_W(BHIST_W), .CTR_W(BCTR_W)) u_branch (
        .clk       (clk),
        .rst       (rst),
        .lookup_pc (lookup_pc),
        .upd_valid (rsv.valid),
        .upd_pc    (res_pc),
        .upd_taken (rsv.taken),
        .dir       (vd.branch_dir)
    );

    tp_selector #(.IDX_W(PATH_W)) u_sel (
        .clk            (clk),
        .rst            (rst),
        .idx            (ghist),
        .upd_valid      (rsv.valid),
        .upd_taken      (rsv.taken),
        .upd_path_dir   (rsv.path_dir),
        .upd_branch_dir (rsv.branch_dir),
        .use_path       (use_path)
    );

    assign vd.final_dir = use_path ? vd.path_dir : vd.branch_dir;

    assign pred_taken  = vd.final_dir;
    assign pred_global = vd.path_dir;
    assign pred_local  = vd.branch_dir;
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int PATH_W = tp_pkg::TP_PATH_W
) (
    input logic              clk,
    input logic              rst,
    input logic              res_valid,
    input logic              res_taken,
    input logic              pred_taken,
    input logic              pred_global,
    input logic              pred_local,
    input logic [PATH_W-1:0] ghist
);
    // R1: first cycle out of reset predicts not taken with clear history
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pred_taken && !pred_global && !pred_local && ghist == '0));

    // R2: resolution shifts the outcome into bit 0 of the path history
    p_hist_shift_r2: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> ghist == {$past(ghist[PATH_W-2:0]), $past(res_taken)});

    // R9: without a resolution the path history holds
    p_hist_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> $stable(ghist));

    // R8: agreeing components decide the final direction
    p_agree_final_r8: assert property (@(posedge clk) disable iff (rst)
        (pred_global == pred_local) |-> (pred_taken == pred_global));

    // R6: the final direction always comes from one of the components
    p_final_source_r6: assert property (@(posedge clk) disable iff (rst)
        (pred_taken == pred_global) || (pred_taken == pred_local));
endmodule

bind tournament_predictor tp_checker #(.PATH_W(PATH_W)) u_tp_checker (
    .clk         (clk),
    .rst         (rst),
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .pred_taken  (pred_taken),
    .pred_global (pred_global),
    .pred_local  (pred_local),
    .ghist       (ghist)
);

// File: tb/tournament_predictor_bench.sv
`timescale 1ns/1ps
module tournament_predictor_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lookup_pc = '0;
    logic        pred_taken, pred_global, pred_local;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic        res_pred_global = 1'b0;
    logic        res_pred_local = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tournament_predictor u_tournament_predictor (
        .clk(clk), .rst(rst), .lookup_pc(lookup_pc),
        .pred_taken(pred_taken), .pred_global(pred_global), .pred_local(pred_local),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_pred_global(res_pred_global), .res_pred_local(res_pred_local)
    );

    // Reference state, built from the requirements
    int m_path [4096];
    int m_sel  [4096];
    int m_bctr [1024];
    int m_bh   [1024];
    int m_gh;

    typedef struct packed { logic [31:0] pc; logic taken; } vec_t;
    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{32'h0000_1000, 1'b1}, '{32'h0000_1004, 1'b0}, '{32'h0000_2040, 1'b1},
        '{32'h0000_1000, 1'b1}, '{32'h0000_3040, 1'b0}, '{32'h0000_1004, 1'b0},
        '{32'h0000_0ffc, 1'b1}, '{32'h0000_1000, 1'b0}, '{32'h0000_2040, 1'b1},
        '{32'h0000_1004, 1'b1}, '{32'h0000_3040, 1'b0}, '{32'h0000_0ffc, 1'b1},
        '{32'h0000_1000, 1'b1}, '{32'h0000_2040, 1'b0}, '{32'h0000_1004, 1'b0},
        '{32'h0000_0ffc, 1'b0}
    };

    function automatic int sat_step(int v, bit up, int maxv);
        if (up) return (v < maxv) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    function automatic bit e_path();
        return m_path[m_gh] >= 2;
    endfunction

    function automatic bit e_branch(logic [31:0] pc);
        return m_bctr[m_bh[pc[11:2]]] >= 4;
    endfunction

    function automatic bit e_final(logic [31:0] pc);
        return (m_sel[m_gh] >= 2) ? e_path() : e_branch(pc);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4096; i++) begin m_path[i] = 1; m_sel[i] = 1; end
        for (int i = 0; i < 1024; i++) begin m_bctr[i] = 3; m_bh[i] = 0; end
        m_gh = 0;
    endtask

    task automatic model_update(logic [31:0] pc, bit tk, bit pg, bit pl);
        int gi, li, h;
        gi = m_gh;
        m_path[gi] = sat_step(m_path[gi], tk, 3);
        if (pg != pl) m_sel[gi] = sat_step(m_sel[gi], pg == tk, 3);
        li = int'(pc[11:2]);
        h = m_bh[li];
        m_bctr[h] = sat_step(m_bctr[h], tk, 7);
        m_bh[li] = ((h << 1) | int'(tk)) & 1023;
        m_gh = ((m_gh << 1) | int'(tk)) & 4095;
    endtask

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Check all three outputs for the address currently presented
    task automatic check_outputs(string ctx, logic [31:0] pc);
        check({ctx, " R3 path dir"},   pred_global, e_path());
        check({ctx, " R5 branch dir"}, pred_local,  e_branch(pc));
        check({ctx, " R6 R7 final"},   pred_taken,  e_final(pc));
    endtask

    // Resolve with explicit component directions (used to steer the selector)
    task automatic resolve(logic [31:0] pc, bit tk, bit pg, bit pl);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = tk;
        res_pred_global = pg; res_pred_local = pl;
        @(posedge clk);
        #1;
        model_update(pc, tk, pg, pl);
        res_valid = 1'b0;
    endtask

    // Lookup, check, then resolve with the directions just predicted
    task automatic branch(string ctx, logic [31:0] pc, bit tk);
        bit pg, pl;
        @(negedge clk);
        lookup_pc = pc;
        #1;
        check_outputs(ctx, pc);
        pg = e_path();
        pl = e_branch(pc);
        resolve(pc, tk, pg, pl);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state for several addresses
        foreach (VEC[k]) begin
            @(negedge clk);
            lookup_pc = VEC[k].pc;
            #1;
            check("R1 final after reset", pred_taken, 1'b0);
            check("R1 path after reset", pred_global, 1'b0);
            check("R1 branch after reset", pred_local, 1'b0);
        end

        // Vector table, several passes (R2 R3 R4 R5 R6 R7 R8)
        for (int pass = 0; pass < 6; pass++) begin
            for (int k = 0; k < NVEC; k++) begin
                branch("table", VEC[k].pc, VEC[k].taken);
            end
        end

        // R4 R5: loop branch, nine taken then one not taken
        for (int rep = 0; rep < 8; rep++) begin
            for (int it = 0; it < 10; it++) begin
                branch("loop", 32'h0000_4200, it != 9);
            end
        end

        // R4: aliasing address shares bits [11:2] with the loop branch
        branch("alias R4", 32'h0000_5200, 1'b0);
        branch("alias R4", 32'h0000_4200, 1'b1);

        // R7: drive the selector toward the path predictor to saturation
        for (int i = 0; i < 20; i++) resolve(32'h0000_0800, 1'b1, 1'b1, 1'b0);
        @(negedge clk); lookup_pc = 32'h0000_0800; #1;
        check_outputs("R7 saturate up", 32'h0000_0800);
        // R7: agreement must not move the selector
        for (int i = 0; i < 6; i++) resolve(32'h0000_0800, 1'b1, 1'b0, 1'b0);
        @(negedge clk); lookup_pc = 32'h0000_0900; #1;
        check_outputs("R7 agree hold", 32'h0000_0900);
        // R7: drive back toward the per-branch predictor and saturate
        for (int i = 0; i < 6; i++) resolve(32'h0000_0800, 1'b1, 1'b0, 1'b1);
        @(negedge clk); lookup_pc = 32'h0000_0800; #1;
        check_outputs("R7 saturate down", 32'h0000_0800);

        // R9: no resolution, outputs stay put across cycles
        @(negedge clk); lookup_pc = 32'h0000_4200; #1;
        check_outputs("R9 before idle", 32'h0000_4200);
        repeat (10) @(posedge clk);
        @(negedge clk); #1;
        check_outputs("R9 after idle", 32'h0000_4200);

        // R10: same-cycle lookup and resolution
        begin
            bit pg, pl;
            @(negedge clk);
            lookup_pc = 32'h0000_1000;
            #1;
            pg = e_path(); pl = e_branch(32'h0000_1000);
            res_valid = 1'b1; res_pc = 32'h0000_1000; res_taken = ~pg;
            res_pred_global = pg; res_pred_local = pl;
            #1;
            check_outputs("R10 pre-edge", 32'h0000_1000);
            @(posedge clk);
            #1;
            model_update(32'h0000_1000, ~pg, pg, pl);
            res_valid = 1'b0;
            #1;
            check_outputs("R10 post-edge", 32'h0000_1000);
        end

        // R1: reset again after training
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        model_reset();
        @(negedge clk); rst = 1'b0; lookup_pc = 32'h0000_4200; #1;
        check("R1 final after re-reset", pred_taken, 1'b0);
        check("R1 path after re-reset", pred_global, 1'b0);
        check("R1 branch after re-reset", pred_local, 1'b0);
        branch("R2 after re-reset", 32'h0000_4200, 1'b1);
        branch("R2 after re-reset", 32'h0000_4200, 1'b1);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule